// File: doc/BRIEF.md
# Temperature-Aware DRAM Refresh Scheduler

This block paces auto-refresh traffic for a DDR3-class memory. A free-running interval counter, sized at elaboration from the controller clock period, marks each point where one more refresh becomes due. The length of the interval follows a case-temperature flag from an external sensor: the normal interval is 7.8 µs, and while the case runs hotter than 85 °C it is halved to 3.9 µs. Each due refresh adds one to a saturating count of owed refreshes.

A sequencer works off the owed count. When the memory controller reports itself busy, refreshes are deferred, up to a backlog of eight. When the backlog is full, a refresh is forced regardless. Before each refresh the sequencer asks for a precharge-all if the controller reports any open bank. It waits out the precharge time, sends the refresh, and then holds a command-block flag for the 160 ns refresh cycle time. All thresholds are whole clock cycles, rounded up from picosecond parameters.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset, no request and no block appear until one interval has passed. The first refresh request is high in the cycle after the (N_norm+1)-th rising edge with reset released, where N_norm = ceil(7.8 µs / clock period).
- R2: With the temperature flag low, the controller idle and all banks closed, refresh requests recur every N_norm cycles.
- R3: With the temperature flag high, refresh requests recur every N_hot = ceil(3.9 µs / clock period) cycles.
- R4: A change of the temperature flag does not restart the interval in progress. The new length applies from the next interval reload, so the gap in progress keeps its old length.
- R5: If banks are reported open when a refresh starts, a one-cycle precharge-all request is issued first. The refresh request follows max(ceil(tRP / period), 2) cycles after it.
- R6: No precharge-all request is issued when banks are reported closed.
- R7: The command-block output is high from the first cycle of a refresh sequence (precharge or refresh). It stays high through N_rfc = ceil(160 ns / period) cycles counted from the refresh request, and drops in the cycle after that window.
- R8: While the controller is busy and fewer than eight refreshes are owed, no sequence starts and the block output stays low. After release, the owed refreshes are issued back to back, one every N_rfc+1 cycles.
- R9: When eight refreshes are owed, a refresh is forced even while the controller is busy. The count never exceeds eight.
- R10: The precharge-all and refresh requests are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hot_i | input | 1 | Case temperature above 85 °C |
| banks_open_i | input | 1 | At least one bank holds an open row |
| ctrl_busy_i | input | 1 | Controller asks for refresh to be deferred |
| pre_all_req_o | output | 1 | One-cycle request for a precharge-all command (A10 high) |
| ref_req_o | output | 1 | One-cycle request for an auto-refresh command |
| cmd_block_o | output | 1 | Other commands must not be issued |

## Verification
The hardest situation to reach from the ports is the forced refresh at a full backlog. It needs the controller held busy across eight complete intervals, with the bench knowing where each interval boundary falls. The stimulus anchors on an observed refresh request and raises the busy input in that cycle. It then predicts the forced request exactly eight and nine intervals later. Finally it releases busy and expects the remaining seven owed refreshes to drain at the spacing set by the refresh cycle time.

// File: rtl/refsch_pkg.sv
// Shared types and elaboration-time helpers for the refresh scheduler.
// Assumes all time parameters are given in picoseconds.
package refsch_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_WAIT_RP,
        ST_REF,
        ST_WAIT_RFC
    } refsch_state_e;

    // Round a picosecond duration up to whole clock cycles.
    function automatic int unsigned cycles_ceil(input int unsigned dur_ps,
                                                input int unsigned period_ps);
        return (dur_ps + period_ps - 1) / period_ps;
    endfunction

endpackage

// File: rtl/refsch_interval.sv
// Interval counter: emits a one-cycle tick each time a refresh falls due.
// The reload length is chosen at the tick from the temperature flag, so a
// flag change never disturbs the interval that is already running.
// Assumes 2 <= HOT_CYC <= NORM_CYC.
module refsch_interval #(
    parameter int unsigned NORM_CYC = 390,
    parameter int unsigned HOT_CYC  = 195
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hot_i,
    output logic tick_o
);
    localparam int unsigned CW = $clog2(NORM_CYC);
    localparam logic [CW-1:0] NORM_LD = CW'(NORM_CYC - 1);
    localparam logic [CW-1:0] HOT_LD  = CW'(HOT_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = (cnt_q == '0);

    // Count down and reload at zero with the length for the current temperature.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= NORM_LD;
        end else if (tick_o) begin
            cnt_q <= hot_i ? HOT_LD : NORM_LD;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assert_span_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= NORM_LD);

    assert_tick_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/refsch_owed.sv
// Owed-refresh counter: adds one per due tick and removes one per issued
// refresh. It saturates at MAX_OWED and reports pending and full.
module refsch_owed #(
    parameter int unsigned MAX_OWED = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc_i,
    input  logic dec_i,
    output logic pending_o,
    output logic full_o
);
    localparam int unsigned OW = $clog2(MAX_OWED + 1);
    localparam logic [OW-1:0] FULL_VAL = OW'(MAX_OWED);

    logic [OW-1:0] owed_q;

    assign pending_o = (owed_q != '0);
    assign full_o    = (owed_q == FULL_VAL);

    // Saturating up/down count; simultaneous inc and dec cancel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed_q <= '0;
        end else begin
            case ({inc_i, dec_i})
                2'b10:   if (owed_q != FULL_VAL) owed_q <= owed_q + 1'b1;
                2'b01:   if (owed_q != '0)       owed_q <= owed_q - 1'b1;
                default: owed_q <= owed_q;
            endcase
        end
    end

    assert_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        owed_q <= FULL_VAL);

    assert_owed_before_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> pending_o);

endmodule

// File: rtl/refsch_seq.sv
// Refresh sequencer: starts a sequence when a refresh is owed and the
// controller allows it (or the backlog is full). It precharges all banks
// when any are open, waits out tRP, issues the refresh, then blocks for tRFC.
// Assumes banks_open_i is sampled only at the start of a sequence.
module refsch_seq
    import refsch_pkg::*;
#(
    parameter int unsigned RP_CYC  = 1,
    parameter int unsigned RFC_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pending_i,
    input  logic full_i,
    input  logic ctrl_busy_i,
    input  logic banks_open_i,
    output logic pre_all_o,
    output logic ref_o,
    output logic block_o
);
    // Cycles spent in each wait state; the command cycle itself counts as one.
    localparam int unsigned N_RP   = (RP_CYC  > 2) ? RP_CYC  - 1 : 1;
    localparam int unsigned N_RFC  = (RFC_CYC > 2) ? RFC_CYC - 1 : 1;
    localparam int unsigned T_MAX  = (N_RP > N_RFC) ? N_RP : N_RFC;
    localparam int unsigned TW     = (T_MAX < 2) ? 1 : $clog2(T_MAX);
    localparam logic [TW-1:0] RP_LD  = TW'(N_RP - 1);
    localparam logic [TW-1:0] RFC_LD = TW'(N_RFC - 1);

    refsch_state_e state_q, state_d;
    logic [TW-1:0] tmr_q, tmr_d;

    assign pre_all_o = (state_q == ST_PRE);
    assign ref_o     = (state_q == ST_REF);
    assign block_o   = (state_q != ST_IDLE);

    // Next-state and wait-timer selection.
    always_comb begin
        state_d = state_q;
        tmr_d   = tmr_q;
        case (state_q)
            ST_IDLE: begin
                if (pending_i && (!ctrl_busy_i || full_i)) begin
                    state_d = banks_open_i ? ST_PRE : ST_REF;
                end
            end
            ST_PRE: begin
                state_d = ST_WAIT_RP;
                tmr_d   = RP_LD;
            end
            ST_WAIT_RP: begin
                if (tmr_q == '0) state_d = ST_REF;
                else             tmr_d   = tmr_q - 1'b1;
            end
            ST_REF: begin
                state_d = ST_WAIT_RFC;
                tmr_d   = RFC_LD;
            end
            ST_WAIT_RFC: begin
                if (tmr_q == '0) state_d = ST_IDLE;
                else             tmr_d   = tmr_q - 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and timer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
        end
    end

    // Checker counter: cycles elapsed since the latest refresh request.
    localparam int unsigned SW = $clog2(RFC_CYC + 1);
    logic [SW-1:0] since_ref_q;
    logic          seen_ref_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_ref_q <= '0;
            seen_ref_q  <= 1'b0;
        end else if (ref_o) begin
            since_ref_q <= SW'(1);
            seen_ref_q  <= 1'b1;
        end else if (since_ref_q < SW'(RFC_CYC)) begin
            since_ref_q <= since_ref_q + 1'b1;
        end
    end

    assert_rfc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_ref_q && since_ref_q < SW'(RFC_CYC)) |-> block_o);

    assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pre_all_o, ref_o}));

    assert_rp_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pre_all_o |=> !ref_o);

    assert_pre_needs_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pre_all_o) |-> $past(banks_open_i));

    assert_busy_defers_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!block_o && ctrl_busy_i && !full_i) |=> !block_o);

    assert_forced_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!block_o && full_i) |=> block_o);

endmodule

// File: rtl/dram_refresh_sched.sv
// Temperature-aware refresh scheduler top: derives every cycle threshold
// from the clock period and wires the interval counter, the owed-refresh
// counter and the sequencer together.
// Assumes CLK_PERIOD_PS divides the timings finely enough that the hot
// interval is at least two cycles.
module dram_refresh_sched
    import refsch_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 20_000,
    parameter int unsigned TREFI_PS      = 7_800_000,
    parameter int unsigned TRFC_PS       = 160_000,
    parameter int unsigned TRP_PS        = 13_750,
    parameter int unsigned MAX_OWED      = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hot_i,
    input  logic banks_open_i,
    input  logic ctrl_busy_i,
    output logic pre_all_req_o,
    output logic ref_req_o,
    output logic cmd_block_o
);
    localparam int unsigned NORM_CYC = cycles_ceil(TREFI_PS, CLK_PERIOD_PS);
    localparam int unsigned HOT_CYC  = cycles_ceil(TREFI_PS / 2, CLK_PERIOD_PS);
    localparam int unsigned RFC_CYC  = cycles_ceil(TRFC_PS, CLK_PERIOD_PS);
    localparam int unsigned RP_CYC   = cycles_ceil(TRP_PS, CLK_PERIOD_PS);

    logic tick;
    logic pending;
    logic full;

    refsch_interval #(
        .NORM_CYC (NORM_CYC),
        .HOT_CYC  (HOT_CYC)
    ) u_interval (
        .clk    (clk),
        .rst_n  (rst_n),
        .hot_i  (hot_i),
        .tick_o (tick)
    );

    refsch_owed #(
        .MAX_OWED (MAX_OWED)
    ) u_owed (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_i     (tick),
        .dec_i     (ref_req_o),
        .pending_o (pending),
        .full_o    (full)
    );

    refsch_seq #(
        .RP_CYC  (RP_CYC),
        .RFC_CYC (RFC_CYC)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .pending_i    (pending),
        .full_i       (full),
        .ctrl_busy_i  (ctrl_busy_i),
        .banks_open_i (banks_open_i),
        .pre_all_o    (pre_all_req_o),
        .ref_o        (ref_req_o),
        .block_o      (cmd_block_o)
    );

endmodule

// File: tb/tb_dram_refresh_sched.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_dram_refresh_sched;

    localparam int unsigned PERIOD_PS = 20_000;
    localparam int N_NORM = (7_800_000 + PERIOD_PS - 1) / PERIOD_PS;
    localparam int N_HOT  = (3_900_000 + PERIOD_PS - 1) / PERIOD_PS;
    localparam int N_RFC  = (160_000 + PERIOD_PS - 1) / PERIOD_PS;
    localparam int RP_RAW = (13_750 + PERIOD_PS - 1) / PERIOD_PS;
    localparam int RP_GAP = (RP_RAW > 2) ? RP_RAW : 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hot = 1'b0;
    logic banks_open = 1'b0;
    logic ctrl_busy = 1'b0;
    logic pre_all_req_o, ref_req_o, cmd_block_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ref_count = 0, pre_count = 0, blk_count = 0, excl_viol = 0;
    int last_ref = 0, last_pre = 0;
    int anchor = 0;
    bit done = 1'b0;
    event mon_ev;

    dram_refresh_sched #(.CLK_PERIOD_PS(PERIOD_PS)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .hot_i         (hot),
        .banks_open_i  (banks_open),
        .ctrl_busy_i   (ctrl_busy),
        .pre_all_req_o (pre_all_req_o),
        .ref_req_o     (ref_req_o),
        .cmd_block_o   (cmd_block_o)
    );

    always #10ns clk = ~clk;

    // Cycle index: 0 right after the last reset edge.
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (ref_req_o)   begin ref_count++; last_ref = cyc; end
            if (pre_all_req_o) begin pre_count++; last_pre = cyc; end
            if (cmd_block_o) blk_count++;
            if (ref_req_o && pre_all_req_o) excl_viol++;
        end
        -> mon_ev;
    end

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_ref(output int at);
        int n0 = ref_count;
        while (ref_count == n0) @(mon_ev);
        at = last_ref;
    endtask

    task automatic wait_pre(output int at);
        int n0 = pre_count;
        while (pre_count == n0) @(mon_ev);
        at = last_pre;
    endtask

    task automatic t_reset;
        int at;
        @(mon_ev);
        chk_eq("R1", "ref at reset", int'(ref_req_o), 0);
        chk_eq("R1", "pre at reset", int'(pre_all_req_o), 0);
        chk_eq("R1", "block at reset", int'(cmd_block_o), 0);
        while (cyc < N_NORM) @(mon_ev);
        chk_eq("R1", "refs before interval", ref_count, 0);
        chk_eq("R1", "block cycles before interval", blk_count, 0);
        wait_ref(at);
        chk_eq("R1", "first ref cycle", at, N_NORM + 1);
        anchor = at;
    endtask

    task automatic t_block;
        int hi = int'(cmd_block_o);
        for (int k = 1; k < N_RFC; k++) begin
            @(mon_ev);
            if (cmd_block_o) hi++;
        end
        chk_eq("R7", "block cycles in tRFC window", hi, N_RFC);
        @(mon_ev);
        chk_eq("R7", "block after window", int'(cmd_block_o), 0);
    endtask

    task automatic t_normal;
        int at;
        wait_ref(at);
        chk_eq("R2", "normal gap", at - anchor, N_NORM);
        anchor = at;
    endtask

    task automatic t_hot;
        int at;
        hot = 1'b1;
        wait_ref(at);
        chk_eq("R4", "gap in progress after heating", at - anchor, N_NORM);
        anchor = at;
        wait_ref(at);
        chk_eq("R3", "hot gap", at - anchor, N_HOT);
        anchor = at;
        hot = 1'b0;
        wait_ref(at);
        chk_eq("R4", "gap in progress after cooling", at - anchor, N_HOT);
        anchor = at;
        wait_ref(at);
        chk_eq("R2", "normal gap after cooling", at - anchor, N_NORM);
        anchor = at;
    endtask

    task automatic t_precharge;
        int p, at;
        int pc0 = pre_count;
        int rc0 = ref_count;
        banks_open = 1'b1;
        wait_pre(p);
        chk_eq("R5", "pre cycle", p - anchor, N_NORM);
        chk_eq("R5", "no ref before pre", ref_count, rc0);
        chk_eq("R7", "block at pre", int'(cmd_block_o), 1);
        banks_open = 1'b0;
        @(mon_ev);
        chk_eq("R7", "block during tRP", int'(cmd_block_o), 1);
        wait_ref(at);
        chk_eq("R5", "ref after pre", at - p, RP_GAP);
        wait_ref(at);
        chk_eq("R2", "gap after precharge path", at - p, N_NORM);
        chk_eq("R6", "no pre with closed banks", pre_count, pc0 + 1);
        anchor = at;
    endtask

    task automatic t_postpone;
        int x, at;
        int rc0 = ref_count;
        ctrl_busy = 1'b1;
        while (cyc < anchor + 3 * N_NORM + 10) @(mon_ev);
        chk_eq("R8", "refs while busy", ref_count, rc0);
        chk_eq("R8", "block while deferred", int'(cmd_block_o), 0);
        x = cyc;
        ctrl_busy = 1'b0;
        for (int k = 0; k < 3; k++) begin
            wait_ref(at);
            chk_eq("R8", "backlog ref cycle", at, x + 1 + k * (N_RFC + 1));
        end
        wait_ref(at);
        chk_eq("R8", "next ref after drain", at - anchor, 4 * N_NORM);
        chk_eq("R8", "ref count after drain", ref_count, rc0 + 4);
        anchor = at;
    endtask

    task automatic t_forced;
        int at, c9;
        int rc0 = ref_count;
        ctrl_busy = 1'b1;
        wait_ref(at);
        chk_eq("R9", "first forced ref", at - anchor, 8 * N_NORM);
        chk_eq("R9", "refs up to forced", ref_count, rc0 + 1);
        wait_ref(at);
        chk_eq("R9", "second forced ref", at - anchor, 9 * N_NORM);
        c9 = at;
        ctrl_busy = 1'b0;
        for (int k = 1; k <= 7; k++) begin
            wait_ref(at);
            chk_eq("R9", "capped backlog drain", at, c9 + k * (N_RFC + 1));
        end
        wait_ref(at);
        chk_eq("R9", "no extra owed beyond cap", at - anchor, 10 * N_NORM);
        anchor = at;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_block();
        t_normal();
        t_hot();
        t_precharge();
        t_postpone();
        t_forced();
        chk_eq("R10", "pre and ref together", excl_viol, 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200_000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule